// File: doc/BRIEF.md
# Stacked-DRAM Regional Load Gate

This block sits beside the command picker of a memory controller that drives a DRAM stack. In that stack, supply droop depends on where a bank sits. Banks are grouped into eight regions. Each region has one of four kinds and is either in the upper dies or in the lower dies. For a candidate command and its target region, the gate answers in the same cycle whether issuing it now keeps every region and the whole stack inside its current-draw budget.

Each command is converted to a load in sixths of a read:

- a read or a write costs six,
- an activate costs three,
- a precharge costs one.

An admitted command keeps its load for a programmable number of cycles, then gives it back. The budget has two parts:

- A per-region ceiling. Lower regions get four reads. Each upper region gets one or two reads, chosen per kind.
- A stack-wide ceiling of sixteen reads. This falls to eight whenever any upper region carries load.

The picker presents one candidate per cycle. It issues the command only when the gate allows it. It raises the valid input in the cycle it commits the command.

Top module: `stack_load_gate`

## Requirements
- R1: Load is counted in sixths of a read. A command's cost comes from `cmd_op`: code 0 is an activate and costs 3, code 1 is a precharge and costs 1, code 2 is a read and costs 6, code 3 is a write and costs 6.
- R2: `cmd_region` bit 2 is set for an upper-die region and clear for a lower-die region. Bits 1:0 give the kind. The load held in a lower region never exceeds LOWER_CAP reads, which is 24 sixths by default.
- R3: An upper region of kind k may hold 2 reads (12 sixths) when UPPER_DOUBLE[k] is set, and 1 read (6 sixths) otherwise. The default UPPER_DOUBLE is 4'b0110.
- R4: While no upper region holds load, the whole stack may hold up to STACK_CAP_IDLE reads, which is 96 sixths by default.
- R5: When any upper region would hold load after admission, the whole stack may hold at most STACK_CAP_BUSY reads, which is 48 sixths by default.
- R6: `cmd_allow` is combinational. It depends on the current candidate and state, whatever `cmd_valid` is. It is high only if the candidate fits both its region ceiling and the stack ceiling.
- R7: Load changes only when `cmd_valid` and `cmd_allow` are both high. A denied or absent command leaves every load unchanged.
- R8: An admitted command's load stays counted for `hold_len` cycles, and a `hold_len` of 0 acts as 1. In the `hold_len`-th cycle after admission, that load is already credited back to `cmd_allow`.
- R9: When a release and an admission fall in the same cycle, both take effect: the freed load counts toward the decision, and the newly admitted load is then held for its own full time.
- R10: Reset clears all held load, so any single command is allowed right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Candidate is being issued this cycle |
| cmd_op | input | 2 | Command code: 0 activate, 1 precharge, 2 read, 3 write |
| cmd_region | input | 3 | Bit 2 upper/lower, bits 1:0 region kind |
| hold_len | input | HOLD_W | Cycles an admitted load stays counted (0 acts as 1) |
| cmd_allow | output | 1 | Candidate fits all ceilings |

## Verification
A load leaving a region and a new command entering that region can fall in the same cycle. The bench provokes this by filling an upper region to its one-read ceiling with a short hold time. It then probes the same region cycle by cycle with a precharge and expects a deny until the release cycle. In the release cycle it issues a real read, which must be allowed. The probes that follow must show the region full again for the whole new hold window, so that a dropped or double-counted release shows up at `cmd_allow`.

// File: rtl/slg_pkg.sv
package slg_pkg;

  localparam int NKIND    = 4;
  localparam int KIND_W   = 2;
  localparam int REGION_W = KIND_W + 1;
  localparam int NREG     = 2 * NKIND;
  localparam int UNIT     = 6;
  localparam int WEIGHT_W = 3;

  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_PRE = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } op_e;

  // Load of one command in sixths of a read (R1)
  function automatic logic [WEIGHT_W-1:0] op_weight(input logic [1:0] op);
    case (op_e'(op))
      OP_ACT:  return WEIGHT_W'(3);
      OP_PRE:  return WEIGHT_W'(1);
      default: return WEIGHT_W'(UNIT);
    endcase
  endfunction

  // Region ceiling in sixths (R2, R3)
  function automatic int unsigned region_cap(input logic [REGION_W-1:0] region,
                                             input int unsigned lower_cap,
                                             input logic [NKIND-1:0] upper_double);
    if (!region[REGION_W-1]) return lower_cap * UNIT;
    return (upper_double[region[KIND_W-1:0]] ? 2 : 1) * UNIT;
  endfunction

endpackage

// File: rtl/slg_release_line.sv
module slg_release_line
  import slg_pkg::*;
#(
  parameter int HOLD_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REGION_W-1:0] wr_region,
  input  logic [WEIGHT_W-1:0] wr_weight,
  input  logic [HOLD_W-1:0]   hold_len,
  output logic                rel_en,
  output logic [REGION_W-1:0] rel_region,
  output logic [WEIGHT_W-1:0] rel_weight
);

  localparam int DEPTH = 2 ** HOLD_W;

  logic [HOLD_W-1:0]   slot_ptr;
  logic [HOLD_W-1:0]   hold_eff;
  logic [HOLD_W-1:0]   rd_idx;
  logic                live_mem   [DEPTH];
  logic [REGION_W-1:0] region_mem [DEPTH];
  logic [WEIGHT_W-1:0] weight_mem [DEPTH];

  // Zero hold acts as one cycle (R8)
  assign hold_eff = (hold_len == '0) ? HOLD_W'(1) : hold_len;
  assign rd_idx   = slot_ptr - hold_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) live_mem[i] <= 1'b0;
    end else begin
      slot_ptr           <= slot_ptr + HOLD_W'(1);
      live_mem[slot_ptr] <= wr_en;
    end
  end

  always_ff @(posedge clk) begin
    region_mem[slot_ptr] <= wr_region;
    weight_mem[slot_ptr] <= wr_weight;
  end

  assign rel_en     = live_mem[rd_idx];
  assign rel_region = region_mem[rd_idx];
  assign rel_weight = weight_mem[rd_idx];

endmodule

// File: rtl/slg_load_counters.sv
module slg_load_counters
  import slg_pkg::*;
#(
  parameter int              CNT_W        = 5,
  parameter int              TOT_W        = 8,
  parameter int              LOWER_CAP    = 4,
  parameter logic [NKIND-1:0] UPPER_DOUBLE = 4'b0110
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       add_en,
  input  logic [REGION_W-1:0]        add_region,
  input  logic [WEIGHT_W-1:0]        add_weight,
  input  logic                       rel_en,
  input  logic [REGION_W-1:0]        rel_region,
  input  logic [WEIGHT_W-1:0]        rel_weight,
  output logic [NREG-1:0][CNT_W-1:0] net_cnt,
  output logic [TOT_W-1:0]           net_total,
  output logic [TOT_W-1:0]           cur_total,
  output logic                       cur_upper_busy
);

  logic [NREG-1:0][CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic rel_hit;
    logic add_hit;
    assign rel_hit = rel_en && (rel_region == REGION_W'(g));
    assign add_hit = add_en && (add_region == REGION_W'(g));
    assign net_cnt[g] = cnt_q[g] - (rel_hit ? CNT_W'(rel_weight) : CNT_W'(0));

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[g] <= '0;
      else        cnt_q[g] <= net_cnt[g] + (add_hit ? CNT_W'(add_weight) : CNT_W'(0));
    end

    // Region ceiling never exceeded (R2 for lower, R3 for upper)
    assert_region_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt_q[g]) <= region_cap(REGION_W'(g), LOWER_CAP, UPPER_DOUBLE));
  end

  always_comb begin
    net_total      = '0;
    cur_total      = '0;
    cur_upper_busy = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      net_total = net_total + TOT_W'(net_cnt[i]);
      cur_total = cur_total + TOT_W'(cnt_q[i]);
      if (i >= NKIND && cnt_q[i] != '0) cur_upper_busy = 1'b1;
    end
  end

  // A release never takes more than the region holds (R8)
  assert_release_covered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> cnt_q[rel_region] >= CNT_W'(rel_weight));

endmodule

// File: rtl/slg_admit_judge.sv
module slg_admit_judge
  import slg_pkg::*;
#(
  parameter int               CNT_W          = 5,
  parameter int               TOT_W          = 8,
  parameter int               LOWER_CAP      = 4,
  parameter int               STACK_CAP_IDLE = 16,
  parameter int               STACK_CAP_BUSY = 8,
  parameter logic [NKIND-1:0] UPPER_DOUBLE   = 4'b0110
) (
  input  logic [NREG-1:0][CNT_W-1:0] net_cnt,
  input  logic [TOT_W-1:0]           net_total,
  input  logic [1:0]                 cand_op,
  input  logic [REGION_W-1:0]        cand_region,
  output logic                       allow
);

  logic [WEIGHT_W-1:0] cand_w;
  logic                upper_after;
  logic                region_fit;
  logic                stack_fit;
  int unsigned         stack_cap;

  assign cand_w = op_weight(cand_op);

  always_comb begin
    upper_after = cand_region[REGION_W-1];
    for (int k = NKIND; k < NREG; k++)
      if (net_cnt[k] != '0) upper_after = 1'b1;
  end

  assign stack_cap  = (upper_after ? STACK_CAP_BUSY : STACK_CAP_IDLE) * UNIT;
  assign region_fit = (32'(net_cnt[cand_region]) + 32'(cand_w))
                      <= region_cap(cand_region, LOWER_CAP, UPPER_DOUBLE);
  assign stack_fit  = (32'(net_total) + 32'(cand_w)) <= stack_cap;
  assign allow      = region_fit && stack_fit;

endmodule

// File: rtl/stack_load_gate.sv
module stack_load_gate
  import slg_pkg::*;
#(
  parameter int               HOLD_W         = 6,
  parameter int               LOWER_CAP      = 4,
  parameter int               STACK_CAP_IDLE = 16,
  parameter int               STACK_CAP_BUSY = 8,
  parameter logic [NKIND-1:0] UPPER_DOUBLE   = 4'b0110
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [2:0]          cmd_region,
  input  logic [HOLD_W-1:0]   hold_len,
  output logic                cmd_allow
);

  localparam int CNT_W = $clog2(LOWER_CAP * UNIT + 1);
  localparam int TOT_W = $clog2(NREG * LOWER_CAP * UNIT + 1);

  logic                       admit;
  logic [WEIGHT_W-1:0]        admit_w;
  logic                       rel_en;
  logic [REGION_W-1:0]        rel_region;
  logic [WEIGHT_W-1:0]        rel_weight;
  logic [NREG-1:0][CNT_W-1:0] net_cnt;
  logic [TOT_W-1:0]           net_total;
  logic [TOT_W-1:0]           cur_total;
  logic                       cur_upper_busy;

  assign admit   = cmd_valid && cmd_allow;
  assign admit_w = op_weight(cmd_op);

  slg_release_line #(.HOLD_W(HOLD_W)) u_release (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (admit),
    .wr_region  (cmd_region),
    .wr_weight  (admit_w),
    .hold_len   (hold_len),
    .rel_en     (rel_en),
    .rel_region (rel_region),
    .rel_weight (rel_weight)
  );

  slg_load_counters #(
    .CNT_W(CNT_W), .TOT_W(TOT_W), .LOWER_CAP(LOWER_CAP), .UPPER_DOUBLE(UPPER_DOUBLE)
  ) u_counters (
    .clk            (clk),
    .rst_n          (rst_n),
    .add_en         (admit),
    .add_region     (cmd_region),
    .add_weight     (admit_w),
    .rel_en         (rel_en),
    .rel_region     (rel_region),
    .rel_weight     (rel_weight),
    .net_cnt        (net_cnt),
    .net_total      (net_total),
    .cur_total      (cur_total),
    .cur_upper_busy (cur_upper_busy)
  );

  slg_admit_judge #(
    .CNT_W(CNT_W), .TOT_W(TOT_W), .LOWER_CAP(LOWER_CAP),
    .STACK_CAP_IDLE(STACK_CAP_IDLE), .STACK_CAP_BUSY(STACK_CAP_BUSY),
    .UPPER_DOUBLE(UPPER_DOUBLE)
  ) u_judge (
    .net_cnt     (net_cnt),
    .net_total   (net_total),
    .cand_op     (cmd_op),
    .cand_region (cmd_region),
    .allow       (cmd_allow)
  );

  // Stack-wide ceilings (R4, R5)
  assert_stack_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cur_total) <= STACK_CAP_IDLE * UNIT);

  assert_busy_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_upper_busy |-> 32'(cur_total) <= STACK_CAP_BUSY * UNIT);

  // A refused command leaves the load alone (R7)
  assert_deny_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!admit && !rel_en) |=> $stable(cur_total));

endmodule

// File: tb/stack_load_gate_test.sv
module stack_load_gate_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd2;
  logic [2:0] cmd_region = 3'd0;
  logic [5:0] hold_len = 6'd63;
  logic       cmd_allow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  stack_load_gate uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_region (cmd_region),
    .hold_len   (hold_len),
    .cmd_allow  (cmd_allow)
  );

  // Codes: 0 ACT, 1 PRE, 2 RD, 3 WR. Fields: {rst, valid, op, region, expect}
  localparam int NV = 34;
  localparam logic [7:0] VEC [NV] = '{
    {1'b0,1'b1,2'd2,3'd0,1'b1}, {1'b0,1'b1,2'd2,3'd0,1'b1},
    {1'b0,1'b1,2'd2,3'd0,1'b1}, {1'b0,1'b1,2'd2,3'd0,1'b1},
    {1'b0,1'b1,2'd1,3'd0,1'b0}, {1'b0,1'b1,2'd0,3'd1,1'b1},
    {1'b0,1'b1,2'd0,3'd1,1'b1}, {1'b0,1'b1,2'd3,3'd1,1'b1},
    {1'b0,1'b1,2'd2,3'd1,1'b1}, {1'b0,1'b1,2'd2,3'd1,1'b1},
    {1'b0,1'b1,2'd2,3'd2,1'b1}, {1'b0,1'b1,2'd2,3'd2,1'b1},
    {1'b0,1'b1,2'd2,3'd4,1'b0}, {1'b0,1'b1,2'd2,3'd3,1'b1},
    {1'b0,1'b1,2'd2,3'd3,1'b1}, {1'b0,1'b1,2'd2,3'd3,1'b1},
    {1'b0,1'b1,2'd2,3'd3,1'b1}, {1'b0,1'b1,2'd2,3'd2,1'b1},
    {1'b0,1'b1,2'd2,3'd2,1'b1}, {1'b0,1'b0,2'd1,3'd4,1'b0},
    {1'b1,1'b0,2'd0,3'd0,1'b0}, {1'b0,1'b1,2'd2,3'd4,1'b1},
    {1'b0,1'b1,2'd1,3'd4,1'b0}, {1'b0,1'b1,2'd2,3'd5,1'b1},
    {1'b0,1'b1,2'd2,3'd5,1'b1}, {1'b0,1'b1,2'd0,3'd5,1'b0},
    {1'b0,1'b1,2'd2,3'd6,1'b1}, {1'b0,1'b1,2'd2,3'd7,1'b1},
    {1'b0,1'b1,2'd1,3'd7,1'b0}, {1'b0,1'b1,2'd2,3'd0,1'b1},
    {1'b0,1'b1,2'd2,3'd0,1'b1}, {1'b0,1'b1,2'd3,3'd1,1'b1},
    {1'b0,1'b1,2'd1,3'd1,1'b0}, {1'b0,1'b1,2'd0,3'd2,1'b0}
  };

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive at the falling edge, judge the combinational answer 1 ns later
  task automatic step(input bit v, input logic [1:0] op, input logic [2:0] rg,
                      input bit exp, input string req);
    @(negedge clk);
    cmd_valid  = v;
    cmd_op     = op;
    cmd_region = rg;
    #1;
    checks++;
    if (cmd_allow !== exp) begin
      fails++;
      $display("FAIL %s: op=%0d region=%0d allow=%b expected=%b", req, op, rg, cmd_allow, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10: any single command fits right after reset
    step(1'b0, 2'd2, 3'd4, 1'b1, "R10");
    step(1'b0, 2'd3, 3'd0, 1'b1, "R10");

    // Table walk: R1 weights, R2/R3 region ceilings, R4/R5 stack ceilings, R7 denial
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][7]) begin
        do_reset();
      end else begin
        step(VEC[i][6], VEC[i][5:4], VEC[i][3:1], VEC[i][0],
             (i < 20) ? "R2_R4_R5_R1" : "R3_R5_R7");
      end
    end

    // R8 and R9: hold of 3 on an upper region holding one read
    do_reset();
    hold_len = 6'd3;
    step(1'b1, 2'd2, 3'd4, 1'b1, "R8");
    step(1'b0, 2'd1, 3'd4, 1'b0, "R8");
    step(1'b0, 2'd1, 3'd4, 1'b0, "R8");
    step(1'b1, 2'd2, 3'd4, 1'b1, "R9");   // release cycle, new read admitted
    step(1'b0, 2'd1, 3'd4, 1'b0, "R9");
    step(1'b0, 2'd1, 3'd4, 1'b0, "R9");
    step(1'b0, 2'd1, 3'd4, 1'b1, "R9");

    // R8: zero hold behaves as one cycle
    do_reset();
    hold_len = 6'd0;
    step(1'b1, 2'd2, 3'd4, 1'b1, "R8");
    step(1'b1, 2'd2, 3'd4, 1'b1, "R8");
    step(1'b0, 2'd1, 3'd4, 1'b1, "R8");

    // R6/R7: a denied valid command must not change the load
    do_reset();
    hold_len = 6'd63;
    step(1'b1, 2'd2, 3'd7, 1'b1, "R6");
    step(1'b1, 2'd0, 3'd7, 1'b0, "R7");
    step(1'b0, 2'd2, 3'd0, 1'b1, "R7");
    step(1'b0, 2'd1, 3'd7, 1'b0, "R6");

    @(negedge clk);
    cmd_valid = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule